// File: doc/BRIEF.md
# Serial Debug Access Port for a 16-bit Word Space

This block is a serial slave that gives an external controller read and write access to an internal space of 16-bit words. The serial link has four wires: clock, active-low select, data in and data out. Each transaction is sent most significant bit first and has three parts: an 8-bit command, a 16-bit word address, and then one or more 16-bit data words. While select stays low after the first data word, every further 16 clocks move to the next address. A long block can therefore be moved without sending the command and address again.

Inside the chip the port drives a simple synchronous register bus. It has an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data returns on the clock after the read strobe. All serial inputs pass through two-flop synchronizers into the system clock, and clock edges are found there. The system clock must therefore run well above the serial clock: each serial clock phase must last at least 4 system clocks. The data-out line is never released. While the port is deselected it shows the run state of the internal processor: 0 when the processor runs and 1 when it is halted.

The controller is a state machine with six states. IDLE waits for select. CMD collects the command. ADDR collects the address. RDATA streams read words. WDATA collects write words. DISCARD swallows the rest of a transaction that has an unknown command. The transitions are:
- IDLE→CMD when select is low.
- CMD→ADDR after the 8th command bit, if the command is a read or a write.
- CMD→DISCARD after the 8th command bit, for any other command.
- ADDR→RDATA or ADDR→WDATA after the 16th address bit.
- Any state→IDLE when select goes high.

Top module: `dbg_spi_port`

## Requirements
- R1: While deselected, spi_miso is driven to cpu_halted (1 = halted, 0 = running), never floated. After reset both bus strobes are low.
- R2: Bits are taken from spi_mosi on rising spi_sck edges, most significant bit first. The first 8 bits are the command: 8'h03 is a read and 8'h02 is a write.
- R3: The 16 bits that follow the command are the word address, most significant bit first.
- R4: In a write, after the 16th bit of each data word, bus_wr pulses for exactly one cycle. During that cycle bus_addr holds the current address and bus_wdata holds the word.
- R5: In a read, bus_rd pulses as soon as the address is complete. The returned word appears on spi_miso most significant bit first, one bit per falling spi_sck edge, starting at the first falling edge after the last address bit.
- R6: With select held low, each additional 16-clock data word uses the previous address plus one, for both reads and writes.
- R7: The address counter wraps from 16'hFFFF to 16'h0000 within a burst.
- R8: Any command other than 8'h02 or 8'h03 makes no bus strobe, and spi_miso stays 0 for the rest of the selected window.
- R9: Raising select in the middle of a word discards that word without a write. The next transaction starts again with a command.
- R10: Reads and writes behave the same whether cpu_halted is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the port |
| spi_miso | output | 1 | Serial data out; shows the halted state when deselected |
| cpu_halted | input | 1 | 1 when the internal processor is stopped |
| bus_addr | output | 16 | Word address on the register bus |
| bus_wdata | output | 16 | Write data on the register bus |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 16 | Read data, valid the cycle after bus_rd |

## Verification
The bench sends these transfer patterns:
- A single write followed by a single read of the same word. This separates the command and address framing from the data path.
- Three-word bursts in each direction. These show whether the address steps by one per word, and whether the read prefetch is ready in time for each new word.
- A burst that starts at the top address. This separates wrapping from saturating.
- An unknown command, and a write cut off after nine data bits. These show that nothing reaches the bus when the framing rules say it must not.
- The same traffic with the processor flagged as halted. This shows that the run state only changes the deselected level of spi_miso.

// File: rtl/dbg_spi_pkg.sv
package dbg_spi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_DISCARD
    } dbg_state_e;
endpackage

// File: rtl/dbg_spi_sync.sv
module dbg_spi_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic cs_n_raw,
    input  logic mosi_raw,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int LAST = SYNC_STAGES - 1;
    localparam logic [2:0] RST_VAL = 3'b010; // {sck, cs_n, mosi}

    logic [2:0] stg [SYNC_STAGES];
    logic       sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= RST_VAL;
            sck_last <= 1'b0;
        end else begin
            stg[0] <= {sck_raw, cs_n_raw, mosi_raw};
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            sck_last <= stg[LAST][2];
        end
    end

    assign sel      = ~stg[LAST][1];
    assign mosi_s   = stg[LAST][0];
    assign sck_rise = sel &  stg[LAST][2] & ~sck_last;
    assign sck_fall = sel & ~stg[LAST][2] &  sck_last;
endmodule

// File: rtl/dbg_spi_ctrl.sv
module dbg_spi_ctrl
    import dbg_spi_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter int          CMD_W     = 8,
    parameter logic [7:0]  CMD_READ  = 8'h03,
    parameter logic [7:0]  CMD_WRITE = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck_rise,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              rd_load,
    output logic              rd_active
);
    localparam int PH_MAX = (ADDR_W > DATA_W) ? ((ADDR_W > CMD_W) ? ADDR_W : CMD_W)
                                              : ((DATA_W > CMD_W) ? DATA_W : CMD_W);
    localparam int CNT_W  = $clog2(PH_MAX);

    dbg_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [PH_MAX-1:0]  shreg_q, sh_nxt;
    logic               is_rd_q;
    logic               ph_last, count_en;
    logic [CMD_W-1:0]   cmd_v;

    assign sh_nxt = {shreg_q[PH_MAX-2:0], mosi_s};
    assign cmd_v  = sh_nxt[CMD_W-1:0];

    always_comb begin
        count_en = 1'b1;
        ph_last  = 1'b0;
        unique case (state_q)
            ST_CMD:   ph_last = (cnt_q == CNT_W'(CMD_W - 1));
            ST_ADDR:  ph_last = (cnt_q == CNT_W'(ADDR_W - 1));
            ST_RDATA, ST_WDATA: ph_last = (cnt_q == CNT_W'(DATA_W - 1));
            ST_IDLE, ST_DISCARD: count_en = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD: if (sck_rise && ph_last)
                    state_d = (cmd_v == CMD_READ || cmd_v == CMD_WRITE) ? ST_ADDR : ST_DISCARD;
                ST_ADDR: if (sck_rise && ph_last)
                    state_d = is_rd_q ? ST_RDATA : ST_WDATA;
                ST_RDATA, ST_WDATA, ST_DISCARD: state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            shreg_q   <= '0;
            is_rd_q   <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
            rd_load   <= 1'b0;
        end else begin
            bus_wr  <= 1'b0;
            bus_rd  <= 1'b0;
            rd_load <= bus_rd;
            if (bus_wr) bus_addr <= bus_addr + 1'b1;
            if (!sel) begin
                cnt_q   <= '0;
                is_rd_q <= 1'b0;
            end else if (sck_rise && count_en) begin
                shreg_q <= sh_nxt;
                cnt_q   <= ph_last ? '0 : cnt_q + 1'b1;
                if (ph_last) begin
                    unique case (state_q)
                        ST_CMD:   is_rd_q <= (cmd_v == CMD_READ);
                        ST_ADDR: begin
                            bus_addr <= sh_nxt[ADDR_W-1:0];
                            bus_rd   <= is_rd_q;
                        end
                        ST_RDATA: begin
                            bus_addr <= bus_addr + 1'b1;
                            bus_rd   <= 1'b1;
                        end
                        ST_WDATA: begin
                            bus_wdata <= sh_nxt[DATA_W-1:0];
                            bus_wr    <= 1'b1;
                        end
                        ST_IDLE, ST_DISCARD: ;
                    endcase
                end
            end
        end
    end

    assign rd_active = (state_q == ST_RDATA);

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);
    // R6
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> bus_addr == $past(bus_addr) + 1'b1);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_wr, bus_rd}));
    // R8
    discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD && $past(state_q) == ST_DISCARD) |-> !bus_wr && !bus_rd);
    // R9
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> state_q == ST_IDLE);
endmodule

// File: rtl/dbg_spi_miso.sv
module dbg_spi_miso #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck_fall,
    input  logic              rd_active,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rdata,
    input  logic              cpu_halted,
    output logic              miso
);
    logic [DATA_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            miso <= 1'b1;
        end else if (!sel) begin
            tx_q <= '0;
            miso <= cpu_halted;
        end else if (!rd_active) begin
            miso <= 1'b0;
        end else if (rd_load) begin
            tx_q <= rdata;
        end else if (sck_fall) begin
            miso <= tx_q[DATA_W-1];
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // R1
    desel_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> miso == $past(cpu_halted));
    // R8
    sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rd_active) |=> !miso);
endmodule

// File: rtl/dbg_spi_port.sv
module dbg_spi_port #(
    parameter int         ADDR_W      = 16,
    parameter int         DATA_W      = 16,
    parameter int         CMD_W       = 8,
    parameter logic [7:0] CMD_READ    = 8'h03,
    parameter logic [7:0] CMD_WRITE   = 8'h02,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              cpu_halted,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic sel, sck_rise, sck_fall, mosi_s, rd_load, rd_active;

    dbg_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .sck_raw(spi_sck), .cs_n_raw(spi_cs_n), .mosi_raw(spi_mosi),
        .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    dbg_spi_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W),
        .CMD_READ(CMD_READ), .CMD_WRITE(CMD_WRITE)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .sel(sel), .sck_rise(sck_rise), .mosi_s(mosi_s),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .rd_load(rd_load), .rd_active(rd_active)
    );

    dbg_spi_miso #(.DATA_W(DATA_W)) miso_i (
        .clk(clk), .rst_n(rst_n),
        .sel(sel), .sck_fall(sck_fall), .rd_active(rd_active),
        .rd_load(rd_load), .rdata(bus_rdata),
        .cpu_halted(cpu_halted), .miso(spi_miso)
    );
endmodule

// File: tb/dbg_spi_port_tb.sv
`timescale 1ns/1ps
module dbg_spi_port_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, halted = 1'b1;
    logic miso, bwr, brd;
    logic [15:0] baddr, bwdata, brdata;

    int total = 0, bad = 0, wcnt = 0, rcnt = 0;
    bit done = 1'b0;
    logic [15:0] mem [256];
    logic [15:0] wl_a [16];
    logic [15:0] wl_d [16];

    always #10 clk = ~clk;

    dbg_spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .cpu_halted(halted),
        .bus_addr(baddr), .bus_wdata(bwdata), .bus_wr(bwr), .bus_rd(brd),
        .bus_rdata(brdata)
    );

    // register-bus model: read data valid the cycle after bus_rd
    always @(posedge clk) begin
        if (brd) begin
            brdata <= mem[baddr[7:0]];
            rcnt   <= rcnt + 1;
        end
        if (bwr) begin
            mem[baddr[7:0]] <= bwdata;
            wl_a[wcnt % 16] <= baddr;
            wl_d[wcnt % 16] <= bwdata;
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        mosi = b;
        wait_clk(HALF);
        r = miso;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic xword(input logic [15:0] w, input int n, output logic [15:0] r);
        logic rb;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            xbit(w[i], rb);
            r[i] = rb;
        end
    endtask

    task automatic begin_xfer(input logic [7:0] cmd, input logic [15:0] a);
        logic [15:0] dummy;
        cs_n = 1'b0;
        wait_clk(HALF);
        xword({8'h00, cmd}, 8, dummy);
        xword(a, 16, dummy);
    endtask

    task automatic end_xfer();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(5 * HALF);
    endtask

    task automatic t_reset();
        chk("R1 miso when halted", miso, 1'b1);
        chk("R1 strobes idle", {bwr, brd}, 2'b00);
        halted = 1'b0;
        wait_clk(4);
        chk("R1 miso when running", miso, 1'b0);
    endtask

    task automatic t_single();
        logic [15:0] r;
        int w0 = wcnt;
        begin_xfer(8'h02, 16'h0010);
        xword(16'hA5C3, 16, r);
        end_xfer();
        chk("R4 one write strobe", wcnt - w0, 1);
        chk("R3 write address", wl_a[w0 % 16], 16'h0010);
        chk("R2 R4 write data", wl_d[w0 % 16], 16'hA5C3);
        begin_xfer(8'h03, 16'h0010);
        xword(16'h0000, 16, r);
        end_xfer();
        chk("R5 single read", r, 16'hA5C3);
    endtask

    task automatic t_burst();
        logic [15:0] r;
        logic [15:0] vals [3] = '{16'h1234, 16'h5678, 16'h9ABC};
        begin_xfer(8'h02, 16'h0020);
        for (int k = 0; k < 3; k++) xword(vals[k], 16, r);
        end_xfer();
        for (int k = 0; k < 3; k++) chk("R6 burst write", mem[8'h20 + k], vals[k]);
        begin_xfer(8'h03, 16'h0020);
        for (int k = 0; k < 3; k++) begin
            xword(16'h0000, 16, r);
            chk("R6 burst read", r, vals[k]);
        end
        end_xfer();
    endtask

    task automatic t_wrap();
        logic [15:0] r;
        int w0 = wcnt;
        begin_xfer(8'h02, 16'hFFFF);
        xword(16'hBEEF, 16, r);
        xword(16'hCAFE, 16, r);
        end_xfer();
        chk("R7 first address", wl_a[w0 % 16], 16'hFFFF);
        chk("R7 wrapped address", wl_a[(w0 + 1) % 16], 16'h0000);
        chk("R7 wrapped data", mem[8'h00], 16'hCAFE);
    endtask

    task automatic t_badcmd();
        logic [15:0] r;
        int w0 = wcnt, r0 = rcnt;
        begin_xfer(8'h55, 16'h0040);
        xword(16'hFFFF, 16, r);
        chk("R8 miso quiet", r, 16'h0000);
        end_xfer();
        chk("R8 no write", wcnt - w0, 0);
        chk("R8 no read", rcnt - r0, 0);
        chk("R8 memory untouched", mem[8'h40], 16'h4040);
    endtask

    task automatic t_abort();
        logic [15:0] r;
        int w0 = wcnt;
        begin_xfer(8'h02, 16'h0030);
        xword(16'h01FF, 9, r);
        end_xfer();
        chk("R9 partial dropped", wcnt - w0, 0);
        chk("R9 memory untouched", mem[8'h30], 16'h1111);
        begin_xfer(8'h02, 16'h0031);
        xword(16'h2222, 16, r);
        end_xfer();
        chk("R9 fresh write address", wl_a[w0 % 16], 16'h0031);
        chk("R9 fresh write data", mem[8'h31], 16'h2222);
    endtask

    task automatic t_halted();
        logic [15:0] r;
        halted = 1'b1;
        wait_clk(4);
        chk("R1 R10 deselected halted", miso, 1'b1);
        begin_xfer(8'h02, 16'h0050);
        xword(16'h0F0F, 16, r);
        end_xfer();
        chk("R10 write when halted", mem[8'h50], 16'h0F0F);
        begin_xfer(8'h03, 16'h0021);
        xword(16'h0000, 16, r);
        end_xfer();
        chk("R10 read when halted", r, 16'h5678);
        chk("R1 back to halted level", miso, 1'b1);
        halted = 1'b0;
        wait_clk(4);
        chk("R1 running level", miso, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i) * 16'h0101;
        mem[8'h30] = 16'h1111;
        brdata = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_single();
        t_burst();
        t_wrap();
        t_badcmd();
        t_abort();
        t_halted();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule